// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Unit

This unit watches the instruction stream of an in-order pipeline that issues instructions alone or as parallel pairs, and keeps cycle statistics for it. Each valid cycle presents one instruction: its functional unit class, up to two source register numbers with enable bits, the destination register if it is a load, a branch-taken flag, a base completion cost in cycles, and flags that mark the first and the last instruction of its issue group.

Registers written by loads in one group form the hazard set for the very next group. An arithmetic, compare or multiply-accumulate instruction that reads a register in that set is charged a two-cycle load-use stall for each matching operand. A branch checks only its single source. A taken branch costs two extra cycles. The cost of each instruction (its base cycles plus any stalls and branch penalty) is summed over the group. The sum is published and added to the running cycle total when the group's last instruction arrives.

Top module: `stall_tracker`

## Requirements
- R1: After reset, every counter, the published group cost and the group-complete pulse read zero.
- R2: A valid load sets the bit of its destination in a pending set. A valid instruction flagged first-of-group moves the pending set into the hazard set and empties the pending set before that instruction's own load is recorded. Such an instruction is itself checked against the moved set, so a load hazards only the next group, and never its own group or any later one.
- R3: Unit codes are 0 execute, 1 compare, 2 multiply-accumulate, 3 branch, 4 load, 5 store. For codes 0 to 2, each enabled source whose register is in the hazard set adds 2 to the load-stall counter and to that instruction's cost, so two matching sources add 4.
- R4: A source whose enable is low never causes a stall, whatever its register number.
- R5: A branch (code 3) checks only its first source for a load-use hit. When taken it adds 2 to the branch-stall counter and 1 to the taken counter; otherwise it adds 1 to the untaken counter.
- R6: Stores and loads never charge a load-use stall, and a store never enters the pending set.
- R7: Instruction cost is base cycles plus load-use stall plus branch penalty. A group's cost is the sum over its instructions from the first-of-group one onward. On a last-of-group instruction, the group-cost output takes that sum in the next cycle, the group-complete output pulses for exactly that cycle, and the sum is added to the total-cycle counter.
- R8: All counters and the group sum are CNT_W bits wide (default 32) and saturate at all ones instead of wrapping.
- R9: A cycle with the valid input low changes no counter and no register set, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid_i | input | 1 | An instruction is presented this cycle |
| grp_first_i | input | 1 | Instruction opens an issue group |
| grp_last_i | input | 1 | Instruction closes an issue group |
| unit_i | input | 3 | Functional unit class code |
| src_a_en_i | input | 1 | First source operand present |
| src_a_i | input | REG_W | First source register number |
| src_b_en_i | input | 1 | Second source operand present |
| src_b_i | input | REG_W | Second source register number |
| load_dst_i | input | REG_W | Destination register of a load |
| br_taken_i | input | 1 | Branch resolved taken |
| base_cyc_i | input | BASE_W | Base completion cycles of the instruction |
| load_stall_cnt_o | output | CNT_W | Accumulated load-use stall cycles |
| branch_stall_cnt_o | output | CNT_W | Accumulated taken-branch penalty cycles |
| taken_cnt_o | output | CNT_W | Taken branches |
| untaken_cnt_o | output | CNT_W | Not-taken branches |
| total_cycles_o | output | CNT_W | Committed cycles of all closed groups |
| group_cycles_o | output | CNT_W | Cost of the most recently closed group |
| group_done_o | output | 1 | One-cycle pulse when a group closes |

## Verification
The assertions assume that the inputs describe well-formed groups. A first-of-group flag opens every group, and a group holds at most two instructions, so the stall counter moves by at most 4 per cycle. They also assume that unit codes come from the six defined classes. The stimulus keeps to this: it builds every group as a single instruction carrying both flags, or as a pair whose first member carries the first flag and whose second carries the last flag. Unit codes are drawn only from 0 to 5. Idle cycles may carry arbitrary flag and operand values, because the block has to ignore them.

// File: rtl/stall_trk_pkg.sv
package stall_trk_pkg;

    typedef enum logic [2:0] {
        UNIT_EXEC   = 3'd0,
        UNIT_CMP    = 3'd1,
        UNIT_MAC    = 3'd2,
        UNIT_BRANCH = 3'd3,
        UNIT_LOAD   = 3'd4,
        UNIT_STORE  = 3'd5
    } unit_e;

    localparam int NSRC          = 2;
    localparam int STALL_PER_HIT = 2;
    localparam int BRANCH_PEN    = 2;

endpackage

// File: rtl/stall_unit_decode.sv
module stall_unit_decode
    import stall_trk_pkg::*;
(
    input  logic [2:0]      unit_i,
    output logic [NSRC-1:0] chk_en_o,
    output logic            is_load_o,
    output logic            is_branch_o
);
    unit_e unit;

    always_comb begin
        unit        = unit_e'(unit_i);
        chk_en_o    = '0;
        is_load_o   = 1'b0;
        is_branch_o = 1'b0;
        case (unit)
            UNIT_EXEC, UNIT_CMP, UNIT_MAC: chk_en_o = '1;
            UNIT_BRANCH: begin
                chk_en_o[0] = 1'b1;
                is_branch_o = 1'b1;
            end
            UNIT_LOAD:  is_load_o = 1'b1;
            default:    chk_en_o = '0;
        endcase
    end
endmodule

// File: rtl/stall_src_check.sv
module stall_src_check #(
    parameter int NUM_REGS      = 16,
    parameter int REG_W         = 4,
    parameter int NSRC          = 2,
    parameter int PEN_W         = 4,
    parameter int STALL_PER_HIT = 2
) (
    input  logic [NUM_REGS-1:0]   mask_i,
    input  logic [NSRC-1:0]       en_i,
    input  logic [NSRC*REG_W-1:0] idx_i,
    output logic [PEN_W-1:0]      stall_o
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = en_i[g] && mask_i[idx_i[g*REG_W +: REG_W]];
    end

    always_comb begin
        stall_o = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (hit[k]) stall_o = stall_o + PEN_W'(STALL_PER_HIT);
        end
    end
endmodule

// File: rtl/stall_sat_add.sv
module stall_sat_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] full;

    always_comb begin
        full  = {1'b0, a_i} + {1'b0, b_i};
        sum_o = full[W] ? '1 : full[W-1:0];
    end
endmodule

// File: rtl/stall_tracker.sv
module stall_tracker
    import stall_trk_pkg::*;
#(
    parameter int  NUM_REGS = 16,
    parameter int  CNT_W    = 32,
    parameter int  BASE_W   = 4,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid_i,
    input  logic              grp_first_i,
    input  logic              grp_last_i,
    input  logic [2:0]        unit_i,
    input  logic              src_a_en_i,
    input  logic [REG_W-1:0]  src_a_i,
    input  logic              src_b_en_i,
    input  logic [REG_W-1:0]  src_b_i,
    input  logic [REG_W-1:0]  load_dst_i,
    input  logic              br_taken_i,
    input  logic [BASE_W-1:0] base_cyc_i,
    output logic [CNT_W-1:0]  load_stall_cnt_o,
    output logic [CNT_W-1:0]  branch_stall_cnt_o,
    output logic [CNT_W-1:0]  taken_cnt_o,
    output logic [CNT_W-1:0]  untaken_cnt_o,
    output logic [CNT_W-1:0]  total_cycles_o,
    output logic [CNT_W-1:0]  group_cycles_o,
    output logic              group_done_o
);
    localparam int PEN_W = $clog2(NSRC*STALL_PER_HIT + 1);

    typedef struct packed {
        logic [NUM_REGS-1:0] pending;
        logic [NUM_REGS-1:0] active;
        logic [CNT_W-1:0]    ld_stall;
        logic [CNT_W-1:0]    br_stall;
        logic [CNT_W-1:0]    taken;
        logic [CNT_W-1:0]    untaken;
        logic [CNT_W-1:0]    total;
        logic [CNT_W-1:0]    grp_acc;
        logic [CNT_W-1:0]    grp_out;
        logic                grp_done;
    } state_t;

    state_t state_d, state_q;

    logic [NSRC-1:0]       chk_en;
    logic                  is_load;
    logic                  is_branch;
    logic [NSRC-1:0]       src_en;
    logic [NUM_REGS-1:0]   haz_mask;
    logic [PEN_W-1:0]      stall;
    logic [CNT_W-1:0]      cost;
    logic [CNT_W-1:0]      acc_base;
    logic [CNT_W-1:0]      acc_sum;
    logic [CNT_W-1:0]      ld_sum, br_sum, tk_sum, ut_sum, tot_sum;

    stall_unit_decode u_dec (
        .unit_i      (unit_i),
        .chk_en_o    (chk_en),
        .is_load_o   (is_load),
        .is_branch_o (is_branch)
    );

    // The opening instruction of a group is checked against the set it moves.
    assign haz_mask = grp_first_i ? state_q.pending : state_q.active;
    assign src_en   = chk_en & {src_b_en_i, src_a_en_i};

    stall_src_check #(
        .NUM_REGS      (NUM_REGS),
        .REG_W         (REG_W),
        .NSRC          (NSRC),
        .PEN_W         (PEN_W),
        .STALL_PER_HIT (STALL_PER_HIT)
    ) u_chk (
        .mask_i  (haz_mask),
        .en_i    (src_en),
        .idx_i   ({src_b_i, src_a_i}),
        .stall_o (stall)
    );

    always_comb begin
        cost = CNT_W'(base_cyc_i) + CNT_W'(stall);
        if (is_branch && br_taken_i) cost = cost + CNT_W'(BRANCH_PEN);
        acc_base = grp_first_i ? '0 : state_q.grp_acc;
    end

    stall_sat_add #(.W(CNT_W)) u_add_ld (
        .a_i(state_q.ld_stall), .b_i(CNT_W'(stall)), .sum_o(ld_sum));
    stall_sat_add #(.W(CNT_W)) u_add_br (
        .a_i(state_q.br_stall), .b_i(CNT_W'(BRANCH_PEN)), .sum_o(br_sum));
    stall_sat_add #(.W(CNT_W)) u_add_tk (
        .a_i(state_q.taken), .b_i(CNT_W'(1)), .sum_o(tk_sum));
    stall_sat_add #(.W(CNT_W)) u_add_ut (
        .a_i(state_q.untaken), .b_i(CNT_W'(1)), .sum_o(ut_sum));
    stall_sat_add #(.W(CNT_W)) u_add_acc (
        .a_i(acc_base), .b_i(cost), .sum_o(acc_sum));
    stall_sat_add #(.W(CNT_W)) u_add_tot (
        .a_i(state_q.total), .b_i(acc_sum), .sum_o(tot_sum));

    always_comb begin
        state_d          = state_q;
        state_d.grp_done = 1'b0;
        if (ins_valid_i) begin
            if (grp_first_i) begin
                state_d.active  = state_q.pending;
                state_d.pending = '0;
            end
            if (is_load) state_d.pending[load_dst_i] = 1'b1;
            state_d.ld_stall = ld_sum;
            if (is_branch) begin
                if (br_taken_i) begin
                    state_d.br_stall = br_sum;
                    state_d.taken    = tk_sum;
                end else begin
                    state_d.untaken  = ut_sum;
                end
            end
            state_d.grp_acc = acc_sum;
            if (grp_last_i) begin
                state_d.total    = tot_sum;
                state_d.grp_out  = acc_sum;
                state_d.grp_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign load_stall_cnt_o   = state_q.ld_stall;
    assign branch_stall_cnt_o = state_q.br_stall;
    assign taken_cnt_o        = state_q.taken;
    assign untaken_cnt_o      = state_q.untaken;
    assign total_cycles_o     = state_q.total;
    assign group_cycles_o     = state_q.grp_out;
    assign group_done_o       = state_q.grp_done;
endmodule

// File: rtl/stall_trk_checker.sv
module stall_trk_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid_i,
    input logic             grp_last_i,
    input logic [2:0]       unit_i,
    input logic [CNT_W-1:0] load_stall_cnt_o,
    input logic [CNT_W-1:0] branch_stall_cnt_o,
    input logic [CNT_W-1:0] taken_cnt_o,
    input logic [CNT_W-1:0] untaken_cnt_o,
    input logic [CNT_W-1:0] total_cycles_o,
    input logic             group_done_o
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    assert_stall_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(load_stall_cnt_o) |->
            (load_stall_cnt_o == $past(load_stall_cnt_o) + CNT_W'(2) ||
             load_stall_cnt_o == $past(load_stall_cnt_o) + CNT_W'(4) ||
             load_stall_cnt_o == ALL1));

    assert_mem_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_i && (unit_i == 3'd4 || unit_i == 3'd5)) |=> $stable(load_stall_cnt_o));

    assert_taken_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(taken_cnt_o) |-> $stable(untaken_cnt_o));

    assert_taken_penalty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(taken_cnt_o) |-> (!$stable(branch_stall_cnt_o) || branch_stall_cnt_o == ALL1));

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        group_done_o |-> $past(ins_valid_i && grp_last_i));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid_i |=> ($stable(total_cycles_o) && $stable(load_stall_cnt_o) && !group_done_o));

    assert_total_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        total_cycles_o >= $past(total_cycles_o));
endmodule

bind stall_tracker stall_trk_checker #(.CNT_W(CNT_W)) u_stall_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .ins_valid_i        (ins_valid_i),
    .grp_last_i         (grp_last_i),
    .unit_i             (unit_i),
    .load_stall_cnt_o   (load_stall_cnt_o),
    .branch_stall_cnt_o (branch_stall_cnt_o),
    .taken_cnt_o        (taken_cnt_o),
    .untaken_cnt_o      (untaken_cnt_o),
    .total_cycles_o     (total_cycles_o),
    .group_done_o       (group_done_o)
);

// File: tb/stall_tracker_tb_top.sv
`timescale 1ns/1ps
module stall_tracker_tb_top;
    localparam int EXEC = 0, CMP = 1, MAC = 2, BR = 3, LD = 4, ST = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       v, f, l, ae, be, tk;
    logic [2:0] u;
    logic [3:0] a, b, dst, base;

    logic [31:0] d_ld, d_br, d_tk, d_ut, d_tot, d_gc;
    logic        d_gd;
    logic [7:0]  s_ld, s_br, s_tk, s_ut, s_tot, s_gc;
    logic        s_gd;

    stall_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid_i(v), .grp_first_i(f), .grp_last_i(l),
        .unit_i(u), .src_a_en_i(ae), .src_a_i(a), .src_b_en_i(be), .src_b_i(b),
        .load_dst_i(dst), .br_taken_i(tk), .base_cyc_i(base),
        .load_stall_cnt_o(d_ld), .branch_stall_cnt_o(d_br), .taken_cnt_o(d_tk),
        .untaken_cnt_o(d_ut), .total_cycles_o(d_tot), .group_cycles_o(d_gc),
        .group_done_o(d_gd));

    stall_tracker #(.CNT_W(8)) sat_i (
        .clk(clk), .rst_n(rst_n), .ins_valid_i(v), .grp_first_i(f), .grp_last_i(l),
        .unit_i(u), .src_a_en_i(ae), .src_a_i(a), .src_b_en_i(be), .src_b_i(b),
        .load_dst_i(dst), .br_taken_i(tk), .base_cyc_i(base),
        .load_stall_cnt_o(s_ld), .branch_stall_cnt_o(s_br), .taken_cnt_o(s_tk),
        .untaken_cnt_o(s_ut), .total_cycles_o(s_tot), .group_cycles_o(s_gc),
        .group_done_o(s_gd));

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural reference: index 0 models the 32-bit instance, 1 the 8-bit one.
    longint m_max [2] = '{64'hFFFF_FFFF, 64'd255};
    bit     m_pend[2][16];
    bit     m_act [2][16];
    longint m_ld[2], m_br[2], m_tk[2], m_ut[2], m_tot[2], m_acc[2], m_gc[2];
    bit     m_gd[2];

    function automatic longint cap(longint x, int k);
        return (x > m_max[k]) ? m_max[k] : x;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int r = 0; r < 16; r++) begin
                m_pend[k][r] = 0;
                m_act[k][r]  = 0;
            end
            m_ld[k] = 0; m_br[k] = 0; m_tk[k] = 0; m_ut[k] = 0;
            m_tot[k] = 0; m_acc[k] = 0; m_gc[k] = 0; m_gd[k] = 0;
        end
    endtask

    task automatic model_step(bit vv, int uu, bit aen, int aa, bit ben, int bb,
                              int dd, bit tt, int bs, bit ff, bit ll);
        for (int k = 0; k < 2; k++) begin
            bit     haz[16];
            longint st;
            longint cst;
            m_gd[k] = 0;
            if (vv) begin
                for (int r = 0; r < 16; r++) haz[r] = ff ? m_pend[k][r] : m_act[k][r];
                if (ff) begin
                    for (int r = 0; r < 16; r++) begin
                        m_act[k][r]  = m_pend[k][r];
                        m_pend[k][r] = 0;
                    end
                end
                st = 0;
                if (uu == EXEC || uu == CMP || uu == MAC) begin
                    if (aen && haz[aa]) st += 2;
                    if (ben && haz[bb]) st += 2;
                end else if (uu == BR) begin
                    if (aen && haz[aa]) st += 2;
                end
                if (uu == LD) m_pend[k][dd] = 1;
                m_ld[k] = cap(m_ld[k] + st, k);
                cst = bs + st;
                if (uu == BR) begin
                    if (tt) begin
                        m_br[k] = cap(m_br[k] + 2, k);
                        m_tk[k] = cap(m_tk[k] + 1, k);
                        cst += 2;
                    end else begin
                        m_ut[k] = cap(m_ut[k] + 1, k);
                    end
                end
                m_acc[k] = cap((ff ? 0 : m_acc[k]) + cst, k);
                if (ll) begin
                    m_tot[k] = cap(m_tot[k] + m_acc[k], k);
                    m_gc[k]  = m_acc[k];
                    m_gd[k]  = 1;
                end
            end
        end
    endtask

    task automatic chk(string what, string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        chk("ld_stall", req, d_ld, m_ld[0]);
        chk("br_stall", req, d_br, m_br[0]);
        chk("taken", req, d_tk, m_tk[0]);
        chk("untaken", req, d_ut, m_ut[0]);
        chk("total", req, d_tot, m_tot[0]);
        chk("grp_cyc", req, d_gc, m_gc[0]);
        chk("grp_done", req, d_gd, m_gd[0]);
        chk("sat ld_stall", req, s_ld, m_ld[1]);
        chk("sat br_stall", req, s_br, m_br[1]);
        chk("sat taken", req, s_tk, m_tk[1]);
        chk("sat untaken", req, s_ut, m_ut[1]);
        chk("sat total", req, s_tot, m_tot[1]);
        chk("sat grp_cyc", req, s_gc, m_gc[1]);
        chk("sat grp_done", req, s_gd, m_gd[1]);
    endtask

    // Called at a falling edge: drive, model, wait one full clock, compare.
    task automatic step(bit vv, int uu, bit aen, int aa, bit ben, int bb, int dd,
                        bit tt, int bs, bit ff, bit ll, string req);
        v = vv; u = 3'(uu); ae = aen; a = 4'(aa); be = ben; b = 4'(bb);
        dst = 4'(dd); tk = tt; base = 4'(bs); f = ff; l = ll;
        model_step(vv, uu, aen, aa, ben, bb, dd, tt, bs, ff, ll);
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic do_reset();
        v = 0; f = 0; l = 0; u = 0; ae = 0; be = 0; a = 0; b = 0; dst = 0; tk = 0; base = 0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        chk("reset ld", "R1", d_ld, 0);
        chk("reset done", "R1", d_gd, 0);

        // load r5 alone, then an execute reading r5 twice
        step(1, LD,   0, 0, 0, 0, 5, 0, 1, 1, 1, "R2");
        step(1, EXEC, 1, 5, 1, 5, 0, 0, 1, 1, 1, "R3");
        chk("double hit", "R3", d_ld, 4);
        chk("grp cost", "R7", d_gc, 5);
        chk("total", "R7", d_tot, 6);
        // two groups later the hazard is gone
        step(1, EXEC, 1, 5, 0, 0, 0, 0, 1, 1, 1, "R2");
        chk("hazard expired", "R2", d_ld, 4);
        // load then use inside one pair: no stall
        step(1, LD,   0, 0, 0, 0, 7, 0, 2, 1, 0, "R2");
        step(1, EXEC, 1, 7, 0, 0, 0, 0, 1, 0, 1, "R2");
        chk("same group", "R2", d_ld, 4);
        chk("pair cost", "R7", d_gc, 3);
        // next group: first source hits, disabled second names r7 too
        step(1, CMP,  1, 7, 0, 7, 0, 0, 1, 1, 1, "R4");
        chk("disabled src", "R4", d_ld, 6);
        // store reads a hazard and writes r10: neither counts
        step(1, LD,   0, 0, 0, 0, 9, 0, 1, 1, 1, "R6");
        step(1, ST,   1, 9, 1, 9, 10, 0, 1, 1, 1, "R6");
        step(1, MAC,  1, 10, 1, 10, 0, 0, 1, 1, 1, "R6");
        chk("store ignored", "R6", d_ld, 6);
        // branches: second source never checked
        step(1, LD,   0, 0, 0, 0, 3, 0, 1, 1, 1, "R5");
        step(1, BR,   1, 4, 1, 3, 0, 1, 1, 1, 1, "R5");
        chk("br src b", "R5", d_ld, 6);
        chk("br stall", "R5", d_br, 2);
        chk("br taken", "R5", d_tk, 1);
        step(1, LD,   0, 0, 0, 0, 8, 0, 1, 1, 1, "R5");
        step(1, BR,   1, 8, 0, 0, 0, 0, 2, 1, 1, "R5");
        chk("br src a hit", "R5", d_ld, 8);
        chk("br untaken", "R5", d_ut, 1);
        // idle with busy-looking inputs
        step(1, LD,   0, 0, 0, 0, 2, 0, 1, 1, 1, "R9");
        step(0, EXEC, 1, 2, 1, 2, 6, 1, 9, 1, 1, "R9");
        step(0, LD,   1, 2, 1, 2, 6, 1, 9, 1, 1, "R9");
        chk("idle done", "R9", d_gd, 0);
        step(1, EXEC, 1, 2, 0, 0, 0, 0, 1, 1, 1, "R9");
        chk("idle kept hazard", "R9", d_ld, 10);

        // randomized well-formed groups
        for (int i = 0; i < 1500; i++) begin
            bit pair;
            pair = 1'($urandom % 2);
            step(1, int'($urandom % 6), 1'($urandom % 2), int'($urandom % 16),
                 1'($urandom % 2), int'($urandom % 16), int'($urandom % 16),
                 1'($urandom % 2), int'($urandom % 16), 1, !pair, "R7");
            if (pair)
                step(1, int'($urandom % 6), 1'($urandom % 2), int'($urandom % 16),
                     1'($urandom % 2), int'($urandom % 16), int'($urandom % 16),
                     1'($urandom % 2), int'($urandom % 16), 0, 1, "R7");
            if ($urandom % 8 == 0)
                step(0, int'($urandom % 6), 1, 0, 1, 0, 0, 1, 5, 1, 1, "R9");
        end

        // saturation run
        do_reset();
        for (int i = 0; i < 70; i++) begin
            step(1, LD,  0, 0, 0, 0, 3, 0, 1, 1, 0, "R8");
            step(1, MAC, 1, 3, 1, 3, 0, 0, 15, 0, 1, "R8");
        end
        for (int i = 0; i < 130; i++)
            step(1, BR, 0, 0, 0, 0, 0, 1, 1, 1, 1, "R8");
        chk("sat ld", "R8", s_ld, 255);
        chk("sat total", "R8", s_tot, 255);
        chk("sat br", "R8", s_br, 255);
        chk("wide ld", "R8", d_ld, 276);
        chk("wide taken", "R8", d_tk, 130);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule